// File: doc/BRIEF.md
# Coprocessor Integer Compare Flag Unit

This block holds a bank of sixteen 64-bit coprocessor registers and compares two of them on request. The result goes back to the host core as a 32-bit status word. The four condition flags sit in the top nibble of that word, and a one-cycle valid strobe marks each new result. The compare is a subtraction, first operand minus second operand. It runs either on the low 32 bits of both registers (narrow mode) or on the full 64 bits (wide mode).

A simple load port writes one register per cycle, so the host or a testbench can set up operands. The control is a two-state machine. ST_IDLE moves to ST_REPORT on a request (transition T_ACCEPT). ST_REPORT stays in ST_REPORT on another request (T_CHAIN), which allows back-to-back compares. ST_REPORT returns to ST_IDLE when there is no request (T_DONE). The flag word is registered when the request is taken and holds its value until the next request.

Top module: `cmpflag_unit`

## Requirements
- R1: After reset, `res_valid` is 0 and `res_word` is all zeros, and every register reads as zero.
- R2: `res_valid` is 1 in exactly the cycles that follow a cycle with `cmp_req` high, so back-to-back requests give back-to-back results.
- R3: The result word carries N at bit 31, Z at bit 30, C at bit 29 and V at bit 28. Bits 27:0 are always zero.
- R4: With `cmp_wide` = 0, only bits 31:0 of each source register take part, and the upper halves have no effect on any flag.
- R5: With `cmp_wide` = 1, all 64 bits of each source register take part.
- R6: The difference is register `src_a` minus register `src_b`. Z is 1 when the difference is zero, and N equals its sign bit.
- R7: C is 1 when (first operand negative and second non-negative), or (first negative and difference non-negative), or (second non-negative and difference non-negative). This equals first >= second when both are read as unsigned.
- R8: V is 1 when the operand signs differ and the sign of the difference differs from the sign of the first operand.
- R9: A load with `ld_en` high writes `ld_data` into register `ld_idx` at the clock edge. A compare requested in the same cycle as a load to one of its sources uses the contents from before the load.
- R10: Between requests, `res_word` keeps the last result unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_en | input | 1 | Register load strobe |
| ld_idx | input | 4 | Register written by a load |
| ld_data | input | 64 | Value written by a load |
| cmp_req | input | 1 | Compare request strobe |
| cmp_wide | input | 1 | 1 selects the 64-bit compare, 0 the 32-bit compare |
| src_a | input | 4 | First operand register (minuend) |
| src_b | input | 4 | Second operand register (subtrahend) |
| res_word | output | 32 | Packed flag word |
| res_valid | output | 1 | High for one cycle per accepted request |

## Verification
The hardest case to reach from the ports is a load and a compare that touch the same register in the same cycle, where the result must reflect the old contents. The stimulus raises `ld_en` and `cmp_req` on the same clock edge for a register whose old and new values give different flags. A second subtle case is narrow mode on registers that match in their low halves but differ in their upper halves. Registers loaded that way must compare equal in narrow mode and unequal in wide mode. Signed extremes at both widths drive the overflow and carry terms into every combination.

// File: rtl/cmpflag_pkg.sv
package cmpflag_pkg;
    localparam int REG_W  = 64;
    localparam int NREGS  = 16;
    localparam int WORD_W = 32;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } cmp_flags_t;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } ctrl_state_t;
endpackage

// File: rtl/cmpflag_regfile.sv
module cmpflag_regfile #(
    parameter int NREGS = 16,
    parameter int W     = 64,
    localparam int IW   = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [W-1:0]  wdata,
    input  logic [IW-1:0] ra_idx,
    input  logic [IW-1:0] rb_idx,
    output logic [W-1:0]  ra_data,
    output logic [W-1:0]  rb_data
);
    logic [W-1:0] bank [NREGS];

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                bank[g] <= '0;
            else if (we && widx == IW'(g))
                bank[g] <= wdata;
        end
    end

    assign ra_data = bank[ra_idx];
    assign rb_data = bank[rb_idx];
endmodule

// File: rtl/cmpflag_lane.sv
module cmpflag_lane
    import cmpflag_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output cmp_flags_t   flags
);
    logic [W-1:0] diff;
    logic a_neg, b_pos, d_pos;

    always_comb begin
        diff  = opa - opb;
        a_neg = opa[W-1];
        b_pos = ~opb[W-1];
        d_pos = ~diff[W-1];
        flags.n = diff[W-1];
        flags.z = (diff == '0);
        flags.c = (a_neg & b_pos) | (a_neg & d_pos) | (b_pos & d_pos);
        flags.v = (opa[W-1] ^ opb[W-1]) & (diff[W-1] ^ opa[W-1]);
    end
endmodule

// File: rtl/cmpflag_ctrl.sv
module cmpflag_ctrl
    import cmpflag_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  cmp_flags_t        flags_in,
    output logic [WORD_W-1:0] word,
    output logic              valid
);
    ctrl_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (req) state_nx = ST_REPORT;           // T_ACCEPT
            ST_REPORT: state_nx = req ? ST_REPORT : ST_IDLE;    // T_CHAIN / T_DONE
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            word <= '0;
        else if (req)
            word <= {flags_in, {(WORD_W-4){1'b0}}};
    end

    always_comb valid = (state == ST_REPORT);

    assert_valid_after_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> valid);
    assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !valid);
    assert_low_bits_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        word[WORD_W-5:0] == '0);
    assert_hold_word_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> $stable(word));
endmodule

// File: rtl/cmpflag_unit.sv
module cmpflag_unit
    import cmpflag_pkg::*;
#(
    parameter int NREGS  = cmpflag_pkg::NREGS,
    parameter int REG_W  = cmpflag_pkg::REG_W,
    parameter int WORD_W = cmpflag_pkg::WORD_W,
    localparam int IW    = $clog2(NREGS),
    localparam int HALF  = REG_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [IW-1:0]     ld_idx,
    input  logic [REG_W-1:0]  ld_data,
    input  logic              cmp_req,
    input  logic              cmp_wide,
    input  logic [IW-1:0]     src_a,
    input  logic [IW-1:0]     src_b,
    output logic [WORD_W-1:0] res_word,
    output logic              res_valid
);
    logic [REG_W-1:0] a_data, b_data;
    cmp_flags_t lane_flags [2];
    cmp_flags_t sel_flags;

    cmpflag_regfile #(.NREGS(NREGS), .W(REG_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(ld_en), .widx(ld_idx), .wdata(ld_data),
        .ra_idx(src_a), .rb_idx(src_b), .ra_data(a_data), .rb_data(b_data)
    );

    for (genvar g = 0; g < 2; g++) begin : g_lane
        localparam int LW = (g == 0) ? HALF : REG_W;
        cmpflag_lane #(.W(LW)) u_lane (
            .opa(a_data[LW-1:0]), .opb(b_data[LW-1:0]), .flags(lane_flags[g])
        );
    end

    assign sel_flags = cmp_wide ? lane_flags[1] : lane_flags[0];

    cmpflag_ctrl #(.WORD_W(WORD_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .req(cmp_req), .flags_in(sel_flags),
        .word(res_word), .valid(res_valid)
    );

    // Equal operands: no sign, no borrow, no overflow (R6, R7, R8)
    assert_equal_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_word[WORD_W-2]) |-> (!res_word[WORD_W-1] && res_word[WORD_W-3] && !res_word[WORD_W-4]));
endmodule

// File: tb/cmpflag_unit_bench.sv
module cmpflag_unit_bench;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        ld_en = 0;
    logic [3:0]  ld_idx = 0;
    logic [63:0] ld_data = 0;
    logic        cmp_req = 0;
    logic        cmp_wide = 0;
    logic [3:0]  src_a = 0;
    logic [3:0]  src_b = 0;
    logic [31:0] res_word;
    logic        res_valid;

    int n_checks = 0;
    int n_fail = 0;
    logic [63:0] shadow [16];
    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic [31:0] last_exp = 0;

    always #10 clk = ~clk;

    cmpflag_unit u_cmpflag_unit (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
        .cmp_req(cmp_req), .cmp_wide(cmp_wide), .src_a(src_a), .src_b(src_b),
        .res_word(res_word), .res_valid(res_valid)
    );

    function automatic logic [31:0] model(input logic [63:0] a, input logic [63:0] b, input logic wide);
        logic [63:0] r;
        logic n, z, c, v;
        if (wide) begin
            r = a - b;
            n = r[63]; z = (r == 0); c = (a >= b);
            v = (a[63] != b[63]) && (r[63] != a[63]);
        end else begin
            r = {32'b0, a[31:0] - b[31:0]};
            n = r[31]; z = (r[31:0] == 0); c = (a[31:0] >= b[31:0]);
            v = (a[31] != b[31]) && (r[31] != a[31]);
        end
        return {n, z, c, v, 28'b0};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic load(input int idx, input logic [63:0] val);
        @(negedge clk);
        ld_en = 1; ld_idx = 4'(idx); ld_data = val;
        @(negedge clk);
        ld_en = 0;
        shadow[idx] = val;
    endtask

    // Drives one request cycle; caller ends the burst with quiet().
    task automatic issue(input int a, input int b, input logic wide, input string tag);
        @(negedge clk);
        cmp_req = 1; src_a = 4'(a); src_b = 4'(b); cmp_wide = wide;
        exp_q.push_back(model(shadow[a], shadow[b], wide));
        tag_q.push_back(tag);
    endtask

    task automatic quiet();
        @(negedge clk);
        cmp_req = 0;
    endtask

    // Monitor: each valid result pops one expected item.
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            if (exp_q.size() == 0) begin
                check("R2 unexpected valid", 32'h1, 32'h0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                last_exp = e;
                check(t, res_word, e);
            end
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) shadow[i] = 0;
        repeat (3) @(negedge clk);
        check("R1 reset valid", {31'b0, res_valid}, 32'h0);
        check("R1 reset word", res_word, 32'h0);
        rst_n = 1;
        issue(9, 10, 1, "R1 registers zero after reset");
        quiet();
        load(1, 64'd5);
        load(2, 64'd7);
        load(3, 64'hFFFF_FFFF_8000_0000);
        load(4, 64'h0000_0000_7FFF_FFFF);
        load(5, 64'h1234_5678_0000_0005);
        load(6, 64'h8000_0000_0000_0000);
        load(7, 64'd1);
        load(8, 64'hFFFF_FFFF_FFFF_FFFF);
        issue(1, 2, 0, "R6 narrow less");       quiet();
        issue(2, 1, 0, "R7 narrow greater");    quiet();
        issue(1, 1, 0, "R6 narrow equal");      quiet();
        issue(1, 5, 0, "R4 upper ignored");     quiet();
        issue(1, 5, 1, "R5 wide uses upper");   quiet();
        issue(3, 4, 0, "R8 narrow min-max");    quiet();
        issue(4, 3, 0, "R8 narrow max-min");    quiet();
        issue(6, 7, 1, "R8 wide overflow");     quiet();
        issue(8, 0, 1, "R7 wide minus one");    quiet();
        issue(0, 8, 1, "R7 wide zero-minus");   quiet();
        // back-to-back burst
        issue(3, 8, 0, "R2 burst 1 R3");
        issue(8, 3, 1, "R2 burst 2 R3");
        issue(7, 6, 1, "R2 burst 3 R8");
        quiet();
        repeat (4) @(negedge clk);
        check("R10 word held", res_word, last_exp);
        check("R2 valid low when idle", {31'b0, res_valid}, 32'h0);
        // same-cycle load and compare on register 1
        @(negedge clk);
        ld_en = 1; ld_idx = 4'd1; ld_data = 64'd99;
        cmp_req = 1; src_a = 4'd1; src_b = 4'd2; cmp_wide = 0;
        exp_q.push_back(model(shadow[1], shadow[2], 0));
        tag_q.push_back("R9 old contents used");
        @(negedge clk);
        ld_en = 0; cmp_req = 0;
        shadow[1] = 64'd99;
        issue(1, 2, 0, "R9 new contents after load"); quiet();
        repeat (3) @(negedge clk);
        check("R2 queue drained", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        check("watchdog", 32'h1, 32'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule